// File: doc/BRIEF.md
# Synthesiser Serial Command Interpreter

This block is the command front end of a frequency synthesiser. It acts as an I2C slave. It accepts tuning and control bytes, turns them into the divide ratio and the control fields that the rest of the synthesiser uses, and returns a status byte when it is read. SCL and SDA are brought into the block's clock domain through a short synchroniser and sampled there. The slave drives SDA only by pulling it low, through `sda_oe`.

After the address byte, the block identifies each data byte by its leading bit. It then pairs that byte with the byte that follows it. A frequency pair carries the low 15 ratio bits. A control pair carries the two top ratio bits, the prescaler enable, a reference ratio code, four port bits and four test-mode bits. The ratio is held in a pending register. It moves to the output only when all 17 bits have been received, or when a STOP closes a transfer that carried ratio data. This lets a host send fine-tuning steps without glitching the loop.

In read mode the block sends status bytes for as long as the host acknowledges them. The status byte carries a power-on flag that is set by reset and cleared once a status byte has been read.

Top module: `synth_i2c_cmd`

## Requirements
- R1: The block answers only the address byte `1100_0 s1 s0 d`, where s1 s0 equal `addr_sel` and d is the direction bit (0 = write, 1 = read). It acknowledges by driving `sda_oe` high during the ninth clock. It does not acknowledge any other address, and it ignores the rest of that transfer.
- R2: The first data byte after the address, and every odd-numbered data byte after it, is classified by bit 7. When bit 7 is 0 it is a frequency-high byte, and its bits 6:0 become pending ratio bits 14:8. The byte that follows a frequency-high byte is a frequency-low byte, and its bits 7:0 become pending ratio bits 7:0.
- R3: A byte with bit 7 = 1 in the classifying slot is a control-A byte. Its bit 6 becomes pending ratio bit 16 and its bit 5 becomes pending ratio bit 15. Its bit 4 drives `pre_en` and its bits 3:0 drive `ref_code`, both from the moment the byte completes.
- R4: The byte that follows a control-A byte is a control-B byte. Its bits 7:4 drive `test_bits` and its bits 3:0 drive `port_bits`, from the moment the byte completes.
- R5: Since the last commit, if frequency-high, frequency-low and control-A bytes have all been received, `div_ratio` takes the pending ratio as the last of them completes.
- R6: A STOP that follows at least one uncommitted ratio-carrying byte commits the pending ratio. Ratio bits that were not resent keep the last value received for them.
- R7: Any number of frequency byte pairs sent without a STOP and without a control-A byte leave `div_ratio` unchanged.
- R8: A STOP that arrives part-way through a byte discards that byte. All outputs keep their values.
- R9: In a write transfer, every data byte is acknowledged.
- R10: A read sends status bytes `{por, 7'b0}`, most significant bit first. `por` is 1 after reset and becomes 0 once a status byte has been fully sent. A host acknowledge causes another status byte to be sent.
- R11: When the host does not acknowledge a status byte, the block ends the read. It releases SDA and drives nothing until the next START.
- R12: After reset, `div_ratio`, `pre_en`, `ref_code`, `port_bits`, `test_bits` and `sda_oe` are all 0.
- R13: `sda_oe` changes only after a falling edge of SCL or after a START or STOP, never while SCL is high within a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, well above the SCL rate |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel | input | 2 | Selects one of four slave addresses |
| sda_oe | output | 1 | 1 pulls SDA low |
| div_ratio | output | 17 | Committed divide ratio |
| pre_en | output | 1 | Prescaler enable |
| ref_code | output | 4 | Reference divider ratio code |
| port_bits | output | 4 | Switching port states |
| test_bits | output | 4 | Test-mode selection |

## Verification
The hardest cases to reach are the commit corners. These are a STOP that cuts a byte short, frequency pairs that are repeated with no STOP, and control and frequency pairs sent in both orders. Each of them depends on the exact order of bus events across several bytes. A bit-level bus master in the bench builds each sequence from START, byte, partial-byte and STOP primitives. A behavioural model of the pending and committed state predicts the outputs after every byte and every STOP.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;

    localparam int RATIO_W  = 17;
    localparam int BYTE_W   = 8;
    localparam int FIELD_W  = 4;
    localparam logic [4:0] ADDR_FIXED = 5'b11000;

    typedef enum logic [2:0] {
        L_IDLE, L_ADDR, L_AACK, L_WDATA, L_WACK, L_RDATA, L_RACK, L_RLOAD
    } link_st_t;

    typedef struct packed {
        logic [FIELD_W-1:0] test;
        logic [FIELD_W-1:0] port;
        logic               pre_en;
        logic [FIELD_W-1:0] ref_code;
    } ctrl_t;

    function automatic logic addr_hit(input logic [6:0] a, input logic [1:0] sel);
        return a == {ADDR_FIXED, sel};
    endfunction

endpackage

// File: rtl/synth_i2c_frontend.sv
module synth_i2c_frontend #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic rise_p,
    output logic fall_p,
    output logic start_p,
    output logic stop_p
);
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;
    logic scl_s;

    assign scl_s   = scl_pipe[SYNC_STAGES-1];
    assign sda_lvl = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_lvl;
        end
    end

    assign rise_p  = scl_s & ~scl_q;
    assign fall_p  = ~scl_s & scl_q;
    assign start_p = scl_s & scl_q & sda_q & ~sda_lvl;
    assign stop_p  = scl_s & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/synth_i2c_link.sv
module synth_i2c_link
    import synth_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_p,
    input  logic              fall_p,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              sda_lvl,
    input  logic [1:0]        addr_sel,
    input  logic [BYTE_W-1:0] status,
    output logic              sda_oe,
    output logic              frame_p,
    output logic              byte_p,
    output logic [BYTE_W-1:0] byte_d,
    output logic              rd_done_p
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    link_st_t          st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic              rw;

    assign byte_d = sh;

    always_ff @(posedge clk) begin
        byte_p    <= 1'b0;
        frame_p   <= 1'b0;
        rd_done_p <= 1'b0;
        if (rst) begin
            st     <= L_IDLE;
            cnt    <= '0;
            sh     <= '0;
            rw     <= 1'b0;
            sda_oe <= 1'b0;
        end else if (start_p) begin
            st     <= L_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (stop_p) begin
            st     <= L_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (st)
                L_ADDR, L_WDATA: begin
                    if (rise_p && cnt != FULL) begin
                        sh  <= {sh[BYTE_W-2:0], sda_lvl};
                        cnt <= cnt + 1'b1;
                    end
                    if (fall_p && cnt == FULL) begin
                        cnt <= '0;
                        if (st == L_WDATA) begin
                            byte_p <= 1'b1;
                            sda_oe <= 1'b1;
                            st     <= L_WACK;
                        end else if (addr_hit(sh[7:1], addr_sel)) begin
                            sda_oe  <= 1'b1;
                            rw      <= sh[0];
                            frame_p <= ~sh[0];
                            st      <= L_AACK;
                        end else begin
                            st <= L_IDLE;
                        end
                    end
                end
                L_AACK, L_RLOAD: begin
                    if (fall_p) begin
                        if (st == L_RLOAD || rw) begin
                            sh     <= status;
                            sda_oe <= ~status[BYTE_W-1];
                            cnt    <= CNT_W'(1);
                            st     <= L_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= L_WDATA;
                        end
                    end
                end
                L_WACK: begin
                    if (fall_p) begin
                        sda_oe <= 1'b0;
                        st     <= L_WDATA;
                    end
                end
                L_RDATA: begin
                    if (fall_p) begin
                        if (cnt == FULL) begin
                            sda_oe <= 1'b0;
                            st     <= L_RACK;
                        end else begin
                            sda_oe <= ~sh[BYTE_W-2];
                            sh     <= {sh[BYTE_W-2:0], 1'b0};
                            cnt    <= cnt + 1'b1;
                        end
                    end
                end
                L_RACK: begin
                    if (rise_p) begin
                        rd_done_p <= 1'b1;
                        st        <= sda_lvl ? L_IDLE : L_RLOAD;
                    end
                end
                default: st <= L_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/synth_i2c_regs.sv
module synth_i2c_regs
    import synth_i2c_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_p,
    input  logic               byte_p,
    input  logic [BYTE_W-1:0]  byte_d,
    input  logic               stop_p,
    output logic [RATIO_W-1:0] ratio,
    output ctrl_t              ctrl
);
    localparam int N_PARTS = 3;

    logic [RATIO_W-1:0] pend, nxt_pend;
    logic [N_PARTS-1:0] got, nxt_got;
    ctrl_t              nxt_ctrl;
    logic               second, kind_ctrl, do_commit;

    always_comb begin
        nxt_pend = pend;
        nxt_got  = got;
        nxt_ctrl = ctrl;
        if (byte_p) begin
            if (!second) begin
                if (!byte_d[7]) begin
                    nxt_pend[14:8] = byte_d[6:0];
                    nxt_got[0]     = 1'b1;
                end else begin
                    nxt_pend[16:15]   = byte_d[6:5];
                    nxt_ctrl.pre_en   = byte_d[4];
                    nxt_ctrl.ref_code = byte_d[3:0];
                    nxt_got[2]        = 1'b1;
                end
            end else if (kind_ctrl) begin
                nxt_ctrl.test = byte_d[7:4];
                nxt_ctrl.port = byte_d[3:0];
            end else begin
                nxt_pend[7:0] = byte_d;
                nxt_got[1]    = 1'b1;
            end
        end
    end

    assign do_commit = (byte_p && (&nxt_got)) || (stop_p && (|got));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= '0;
            got       <= '0;
            ratio     <= '0;
            ctrl      <= '0;
            second    <= 1'b0;
            kind_ctrl <= 1'b0;
        end else begin
            pend <= nxt_pend;
            ctrl <= nxt_ctrl;
            if (do_commit) begin
                ratio <= nxt_pend;
                got   <= '0;
            end else begin
                got <= nxt_got;
            end
            if (frame_p || stop_p) begin
                second <= 1'b0;
            end else if (byte_p) begin
                second <= ~second;
                if (!second) kind_ctrl <= byte_d[7];
            end
        end
    end
endmodule

// File: rtl/synth_i2c_cmd.sv
module synth_i2c_cmd
    import synth_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [1:0]         addr_sel,
    output logic               sda_oe,
    output logic [RATIO_W-1:0] div_ratio,
    output logic               pre_en,
    output logic [FIELD_W-1:0] ref_code,
    output logic [FIELD_W-1:0] port_bits,
    output logic [FIELD_W-1:0] test_bits
);
    logic sda_lvl, rise_p, fall_p, start_p, stop_p;
    logic frame_p, byte_p, rd_done_p;
    logic [BYTE_W-1:0] byte_d;
    logic por_flag;
    ctrl_t ctrl;

    synth_i2c_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_fe (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_lvl(sda_lvl), .rise_p(rise_p), .fall_p(fall_p),
        .start_p(start_p), .stop_p(stop_p)
    );

    synth_i2c_link u_link (
        .clk(clk), .rst(rst), .rise_p(rise_p), .fall_p(fall_p),
        .start_p(start_p), .stop_p(stop_p), .sda_lvl(sda_lvl),
        .addr_sel(addr_sel), .status({por_flag, 7'b0}),
        .sda_oe(sda_oe), .frame_p(frame_p), .byte_p(byte_p),
        .byte_d(byte_d), .rd_done_p(rd_done_p)
    );

    synth_i2c_regs u_regs (
        .clk(clk), .rst(rst), .frame_p(frame_p), .byte_p(byte_p),
        .byte_d(byte_d), .stop_p(stop_p), .ratio(div_ratio), .ctrl(ctrl)
    );

    always_ff @(posedge clk) begin
        if (rst)            por_flag <= 1'b1;
        else if (rd_done_p) por_flag <= 1'b0;
    end

    assign pre_en    = ctrl.pre_en;
    assign ref_code  = ctrl.ref_code;
    assign port_bits = ctrl.port;
    assign test_bits = ctrl.test;
endmodule

// File: rtl/synth_i2c_sva.sv
module synth_i2c_sva (
    input logic        clk,
    input logic        rst,
    input logic        sda_oe,
    input logic [16:0] div_ratio,
    input logic [3:0]  port_bits,
    input logic [3:0]  test_bits,
    input logic        byte_p,
    input logic        stop_p,
    input logic        start_p,
    input logic        fall_p,
    input logic        por_flag
);
    a_r5_ratio_moves_on_event: assert property (@(posedge clk) disable iff (rst)
        !$stable(div_ratio) |-> $past(byte_p || stop_p));

    a_r4_fields_move_on_byte: assert property (@(posedge clk) disable iff (rst)
        !$stable({port_bits, test_bits}) |-> $past(byte_p));

    a_r10_por_never_sets: assert property (@(posedge clk) disable iff (rst)
        !$rose(por_flag));

    a_r11_release_on_stop: assert property (@(posedge clk) disable iff (rst)
        stop_p |=> !sda_oe);

    a_r13_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(fall_p || start_p || stop_p));
endmodule

bind synth_i2c_cmd synth_i2c_sva u_sva (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .div_ratio(div_ratio),
    .port_bits(port_bits), .test_bits(test_bits), .byte_p(byte_p),
    .stop_p(stop_p), .start_p(start_p), .fall_p(fall_p), .por_flag(por_flag)
);

// File: tb/tb_synth_i2c_cmd.sv
module tb_synth_i2c_cmd;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] addr_sel = 2'b01;
    logic sda_oe, pre_en;
    logic [16:0] div_ratio;
    logic [3:0] ref_code, port_bits, test_bits;
    wire sda_line = sda_m & ~sda_oe;

    int checks = 0, errors = 0;
    bit done = 0;

    // behavioural model of the command state
    logic [16:0] m_pend = '0, m_ratio = '0;
    bit m_gh = 0, m_gl = 0, m_gc = 0, m_second = 0, m_kctl = 0;
    logic m_pe = 0;
    logic [3:0] m_ref = '0, m_port = '0, m_test = '0;

    always #2 clk = ~clk;

    synth_i2c_cmd dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel(addr_sel), .sda_oe(sda_oe), .div_ratio(div_ratio),
        .pre_en(pre_en), .ref_code(ref_code), .port_bits(port_bits),
        .test_bits(test_bits)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_frame();
        m_second = 0;
    endtask

    task automatic model_byte(input logic [7:0] b);
        if (!m_second) begin
            m_kctl = b[7];
            if (!b[7]) begin m_pend[14:8] = b[6:0]; m_gh = 1; end
            else begin
                m_pend[16:15] = b[6:5]; m_pe = b[4]; m_ref = b[3:0]; m_gc = 1;
            end
        end else if (m_kctl) begin
            m_test = b[7:4]; m_port = b[3:0];
        end else begin
            m_pend[7:0] = b; m_gl = 1;
        end
        m_second = !m_second;
        if (m_gh && m_gl && m_gc) begin
            m_ratio = m_pend; m_gh = 0; m_gl = 0; m_gc = 0;
        end
    endtask

    task automatic model_stop();
        if (m_gh || m_gl || m_gc) begin
            m_ratio = m_pend; m_gh = 0; m_gl = 0; m_gc = 0;
        end
        m_second = 0;
    endtask

    task automatic check_state(input string req);
        chk(req, 32'(div_ratio), 32'(m_ratio));
        chk(req, 32'({pre_en, ref_code, port_bits, test_bits}),
            32'({m_pe, m_ref, m_port, m_test}));
    endtask

    task automatic bus_start();
        sda_m = 1; scl_m = 1; wclk(Q);
        sda_m = 0; wclk(Q);
        scl_m = 0; wclk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; wclk(Q);
        scl_m = 1; wclk(Q);
        sda_m = 1; wclk(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wclk(Q);
        scl_m = 1; wclk(2 * Q);
        scl_m = 0; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1; wclk(Q);
        scl_m = 1; wclk(Q);
        ack = ~sda_line; wclk(Q);
        scl_m = 0; wclk(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            wclk(Q); scl_m = 1; wclk(Q);
            b[i] = sda_line; wclk(Q);
            scl_m = 0;
        end
        sda_m = ~give_ack; wclk(Q);
        scl_m = 1; wclk(2 * Q);
        scl_m = 0; wclk(2);
        sda_m = 1; wclk(Q);
    endtask

    task automatic wr(input logic [7:0] b, input string req);
        logic a;
        send_byte(b, a);
        chk({req, " R9 ack"}, 32'(a), 32'd1);
        model_byte(b);
        check_state(req);
    endtask

    task automatic stop_and_check(input string req);
        bus_stop();
        model_stop();
        wclk(Q);
        check_state(req);
    endtask

    task automatic open_write(input logic [7:0] a8);
        logic a;
        bus_start();
        send_byte(a8, a);
        chk("R1 write address ack", 32'(a), 32'd1);
        model_frame();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] rb;
        wclk(5);
        rst = 0;
        wclk(5);
        // R12 reset state
        check_state("R12 reset outputs");
        chk("R12 sda released", 32'(sda_oe), 32'd0);

        // R10 status read: por set, then cleared, R11 nack ends read
        bus_start();
        send_byte(8'hC3, a);
        chk("R1 read address ack", 32'(a), 32'd1);
        recv_byte(1'b1, rb);
        chk("R10 first status por=1", 32'(rb), 32'h80);
        recv_byte(1'b0, rb);
        chk("R10 second status por cleared", 32'(rb), 32'h00);
        wclk(3 * Q);
        chk("R11 released after nack", 32'(sda_oe), 32'd0);
        bus_stop();

        // R1 wrong address ignored
        bus_start();
        send_byte(8'hC0, a);
        chk("R1 wrong address no ack", 32'(a), 32'd0);
        send_byte(8'h12, a);
        chk("R1 ignored data no ack", 32'(a), 32'd0);
        bus_stop();
        wclk(Q);
        check_state("R1 ignored frame no effect");

        // R2 R6 frequency pair then STOP
        open_write(8'hC2);
        wr(8'h12, "R2 freq high pending");
        wr(8'h34, "R2 freq low pending");
        stop_and_check("R6 stop commits freq pair");
        chk("R6 ratio value", 32'(div_ratio), 32'h01234);

        // R7 repeated freq pairs without STOP
        open_write(8'hC2);
        wr(8'h05, "R7 pair1 hi");
        wr(8'h66, "R7 pair1 lo");
        wr(8'h07, "R7 pair2 hi");
        wr(8'h77, "R7 pair2 lo");
        chk("R7 ratio unchanged", 32'(div_ratio), 32'h01234);
        stop_and_check("R6 stop after repeats");

        // R5 R3 R4 freq then control
        open_write(8'hC2);
        wr(8'h12, "R5 hi");
        wr(8'h34, "R5 lo");
        wr(8'hE5, "R5 R3 ctrlA completes word");
        chk("R5 commit value", 32'(div_ratio), 32'h19234);
        chk("R3 ref code", 32'(ref_code), 32'h5);
        wr(8'hA9, "R4 ctrlB fields");
        chk("R4 port/test", 32'({test_bits, port_bits}), 32'hA9);
        stop_and_check("R6 stop with nothing pending");

        // R5 control then freq
        open_write(8'hC2);
        wr(8'h9A, "R3 ctrlA pe/ref");
        chk("R3 pre_en", 32'(pre_en), 32'd1);
        wr(8'h3C, "R4 ctrlB");
        wr(8'h55, "R5 hi not yet complete");
        wr(8'h66, "R5 lo completes word");
        chk("R5 order ctrl-first value", 32'(div_ratio), 32'h05566);
        stop_and_check("R5 post stop");

        // R6 single bytes then STOP
        open_write(8'hC2);
        wr(8'h7F, "R6 lone freq high");
        stop_and_check("R6 lone freq high stop");
        chk("R6 partial update value", 32'(div_ratio), 32'h07F66);
        open_write(8'hC2);
        wr(8'hE0, "R6 lone ctrlA");
        stop_and_check("R6 lone ctrlA stop");
        chk("R6 ctrlA stop value", 32'(div_ratio), 32'h1FF66);

        // R8 STOP inside a byte
        open_write(8'hC2);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        wclk(Q);
        check_state("R8 partial byte discarded");
        chk("R8 ratio kept", 32'(div_ratio), 32'h1FF66);

        // R1 other address select
        addr_sel = 2'b10;
        wclk(Q);
        bus_start();
        send_byte(8'hC2, a);
        chk("R1 old address now ignored", 32'(a), 32'd0);
        bus_stop();
        open_write(8'hC4);
        wr(8'h01, "R1 new address hi");
        wr(8'h02, "R1 new address lo");
        stop_and_check("R1 new address commit");
        chk("R1 new address value", 32'(div_ratio), 32'h18102);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule